// File: doc/BRIEF.md
# Switching Clock Source Selector

This block supplies the time base for a power-stage controller. A single shared input pin can be in one of three conditions. Tied low, it leaves the controller free to choose between pulse-width and pulse-frequency regulation, and the internal reference clock is used. Held high, it requests fixed-frequency pulse-width regulation and the internal reference clock is still used. Toggling, it carries an external high-frequency clock that becomes the time base, and pulse-frequency regulation is then forbidden.

The pin is synchronized into the system clock domain. An activity detector counts pin edges against the internal reference, which arrives as a one-cycle `osc_pulse` enable. A shared divide-by-22 counter turns the active source into a one-cycle switching tick. A three-state machine decides the source:
- `ST_INTERNAL`: internal source, pin treated as a static level.
- `ST_ARMED`: clock activity found, waiting for the divider's terminal count.
- `ST_EXTERNAL`: the pin's rising edges drive the divider.

The transitions are:
- `found`: `ST_INTERNAL` to `ST_ARMED`.
- `commit`: `ST_ARMED` to `ST_EXTERNAL`, taken at the terminal count.
- `abort`: `ST_ARMED` to `ST_INTERNAL`, taken when activity is lost.
- `lost`: `ST_EXTERNAL` to `ST_INTERNAL`.

Top module: `swclk_src_sel`

## Requirements
- R1: After reset `sw_tick` is 0, `pwm_only` is 0, `pfm_en` is 1, the divider count is zero and the internal source is selected.
- R2: With the internal source selected, `sw_tick` pulses once for every 22 `osc_pulse` cycles. The tick is registered, so it appears one clock after the 22nd pulse.
- R3: In `ST_INTERNAL` the pin level passes through two synchronizer flops. A high level gives `pwm_only`=1 and `pfm_en`=0, and a low level gives `pwm_only`=0 and `pfm_en`=1. The tick keeps its internal period in both cases.
- R4: An edge counter runs over windows of 64 `osc_pulse` cycles and restarts at each window's end. The pin counts as a clock only when 4 synchronized edges (either polarity) fall inside one window. With fewer edges the state stays `ST_INTERNAL`.
- R5: In `ST_EXTERNAL` the divider counts synchronized rising edges of the pin, and `sw_tick` pulses once every 22 of them.
- R6: The move from `ST_ARMED` to `ST_EXTERNAL` happens only on the `osc_pulse` that completes a divider period, and that move is signalled by the tick. No tick interval is ever shorter than a full period of either source.
- R7: In `ST_ARMED` and `ST_EXTERNAL`, `pwm_only` is 1 and `pfm_en` is 0 regardless of the pin level.
- R8: Outside `ST_INTERNAL`, 64 `osc_pulse` cycles with no pin edge return the block to `ST_INTERNAL`. The divider keeps its count and continues on `osc_pulse`, and the flags follow the static level again.
- R9: `sw_tick` never stays high for two cycles in a row, and `pfm_en` is always the complement of `pwm_only`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; it must be several times faster than the external clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_pulse | input | 1 | One-cycle enable at the internal reference rate |
| sync_pin | input | 1 | Shared pin: static level or external clock (asynchronous) |
| sw_tick | output | 1 | One-cycle switching-cycle tick |
| pfm_en | output | 1 | Pulse-frequency regulation permitted |
| pwm_only | output | 1 | Pulse-width regulation forced |

## Verification
A pin change reaches `pwm_only` and `pfm_en` two clocks later: one clock per synchronizer flop, and the flags are combinational from the second flop and the state. A tick appears one clock after the source event that completes the count, and the source event from the pin comes three flops after the pin. The bench model applies these same latencies, and the comparison runs 1 ns after each falling edge, so every value due at a rising edge is sampled once it has settled. Scenario checks measure tick intervals in whole clocks (66 for a pulse every third clock, 88 for a pin period of four clocks). Waits for detection and loss exceed the 64-pulse windows by a margin, so every check falls after its result is due.

// File: rtl/swsel_pkg.sv
package swsel_pkg;
    typedef enum logic [1:0] {
        ST_INTERNAL = 2'd0,
        ST_ARMED    = 2'd1,
        ST_EXTERNAL = 2'd2
    } sel_state_e;
endpackage

// File: rtl/swsel_sync.sv
module swsel_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic lvl,
    output logic any_edge,
    output logic rise
);
    localparam int LEN = STAGES + 1;
    logic [LEN-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[LEN-2:0], pin};
    end

    // chain[STAGES-1] is the synchronized level, chain[STAGES] its delayed copy
    assign lvl      = chain[STAGES-1];
    assign any_edge = chain[STAGES-1] ^ chain[STAGES];
    assign rise     = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/swsel_activity.sv
module swsel_activity #(
    parameter int WIN   = 64,
    parameter int EDGES = 4,
    parameter int IDLE  = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc,
    input  logic any_edge,
    input  logic hunting,
    output logic found,
    output logic lost
);
    localparam int WW = (WIN  > 1) ? $clog2(WIN)       : 1;
    localparam int EW = $clog2(EDGES + 1);
    localparam int IW = (IDLE > 1) ? $clog2(IDLE)      : 1;

    logic [WW-1:0] win_cnt;
    logic [EW-1:0] edge_cnt;
    logic [IW-1:0] idle_cnt;
    logic          win_end;

    assign win_end = osc && (win_cnt == WW'(WIN - 1));
    assign found   = hunting && any_edge && (edge_cnt == EW'(EDGES - 1));
    assign lost    = !hunting && osc && !any_edge && (idle_cnt == IW'(IDLE - 1));

    // edge counting inside fixed windows while hunting for a clock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_cnt  <= '0;
            edge_cnt <= '0;
        end else if (!hunting || found || win_end) begin
            win_cnt  <= '0;
            edge_cnt <= '0;
        end else begin
            win_cnt  <= win_cnt + WW'(osc);
            edge_cnt <= edge_cnt + EW'(any_edge);
        end
    end

    // quiet-time counter while a clock is believed present
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      idle_cnt <= '0;
        else if (hunting || lost)        idle_cnt <= '0;
        else if (any_edge)               idle_cnt <= '0;
        else                             idle_cnt <= idle_cnt + IW'(osc);
    end
endmodule

// File: rtl/swsel_divider.sv
module swsel_divider #(
    parameter int DIV = 22,
    localparam int CW = $clog2(DIV)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ev,
    output logic          tc,
    output logic [CW-1:0] cnt
);
    assign tc = ev && (cnt == CW'(DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  cnt <= '0;
        else if (tc) cnt <= '0;
        else if (ev) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/swclk_src_sel.sv
module swclk_src_sel
    import swsel_pkg::*;
#(
    parameter int DIV         = 22,
    parameter int SYNC_STAGES = 2,
    parameter int WIN         = 64,
    parameter int EDGES       = 4,
    parameter int IDLE        = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_pulse,
    input  logic sync_pin,
    output logic sw_tick,
    output logic pfm_en,
    output logic pwm_only
);
    localparam int CW = $clog2(DIV);

    sel_state_e    state_q, state_d;
    logic          pin_lvl, pin_edge, pin_rise;
    logic          found, lost, src_ev, div_tc;
    logic [CW-1:0] div_cnt;

    swsel_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin(sync_pin),
        .lvl(pin_lvl), .any_edge(pin_edge), .rise(pin_rise)
    );

    swsel_activity #(.WIN(WIN), .EDGES(EDGES), .IDLE(IDLE)) u_act (
        .clk(clk), .rst_n(rst_n), .osc(osc_pulse), .any_edge(pin_edge),
        .hunting(state_q == ST_INTERNAL), .found(found), .lost(lost)
    );

    assign src_ev = (state_q == ST_EXTERNAL) ? pin_rise : osc_pulse;

    swsel_divider #(.DIV(DIV)) u_div (
        .clk(clk), .rst_n(rst_n), .ev(src_ev), .tc(div_tc), .cnt(div_cnt)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_INTERNAL: if (found) state_d = ST_ARMED;
            ST_ARMED: begin
                if (lost)        state_d = ST_INTERNAL;
                else if (div_tc) state_d = ST_EXTERNAL;
            end
            ST_EXTERNAL: if (lost) state_d = ST_INTERNAL;
            default:     state_d = ST_INTERNAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_INTERNAL;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sw_tick <= 1'b0;
        else        sw_tick <= div_tc;
    end

    always_comb begin
        pwm_only = (state_q != ST_INTERNAL) || pin_lvl;
        pfm_en   = !pwm_only;
    end
endmodule

// File: rtl/swclk_src_sel_chk.sv
module swclk_src_sel_chk
    import swsel_pkg::*;
#(
    parameter int DIV = 22,
    localparam int CW = $clog2(DIV)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick,
    input logic          pwm_only,
    input logic          pfm_en,
    input sel_state_e    state,
    input logic          lvl,
    input logic          src_ev,
    input logic [CW-1:0] div_cnt
);
    p_tick_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    p_clock_forces_pwm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_INTERNAL) |-> (pwm_only && !pfm_en));

    p_static_low_pfm_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INTERNAL && !lvl) |-> (pfm_en && !pwm_only));

    p_commit_at_tc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXTERNAL && $past(state) == ST_ARMED) |-> tick);

    p_tick_after_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> $past(src_ev));

    p_div_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        div_cnt < CW'(DIV));
endmodule

bind swclk_src_sel swclk_src_sel_chk #(.DIV(DIV)) chk_i (
    .clk(clk), .rst_n(rst_n), .tick(sw_tick), .pwm_only(pwm_only),
    .pfm_en(pfm_en), .state(state_q), .lvl(pin_lvl), .src_ev(src_ev),
    .div_cnt(div_cnt)
);

// File: tb/swclk_src_sel_tb_top.sv
`timescale 1ns/1ps
module swclk_src_sel_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic osc_pulse = 1'b0;
    logic sync_pin = 1'b0;
    logic sw_tick, pfm_en, pwm_only;

    always #2 clk = ~clk;

    swclk_src_sel dut_i (
        .clk(clk), .rst_n(rst_n), .osc_pulse(osc_pulse), .sync_pin(sync_pin),
        .sw_tick(sw_tick), .pfm_en(pfm_en), .pwm_only(pwm_only)
    );

    int n_checks = 0;
    int n_fail   = 0;
    string phase_req = "R1";

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---------------- stimulus generators (drive at falling edge) -----------
    int  osc_div = 3;
    int  osc_ph  = 0;
    bit  pin_toggle = 0;
    bit  pin_level  = 0;
    int  pin_ph     = 0;
    always @(negedge clk) begin
        osc_ph    = (osc_ph + 1) % osc_div;
        osc_pulse <= (osc_ph == 0);
        if (pin_toggle) begin
            pin_ph = (pin_ph + 1) % 2;
            if (pin_ph == 0) sync_pin <= ~sync_pin;
        end else begin
            sync_pin <= pin_level;
        end
    end

    // ---------------- behavioural reference model ---------------------------
    int m_s1, m_s2, m_s3;
    int m_state;      // 0 internal, 1 armed, 2 external
    int m_wcnt, m_ecnt, m_icnt, m_dcnt;
    int m_tick;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_s3 = 0; m_state = 0;
            m_wcnt = 0; m_ecnt = 0; m_icnt = 0; m_dcnt = 0; m_tick = 0;
        end else begin
            int edg, ris, osc, fnd, lst, ev, tc, nstate;
            edg = (m_s2 != m_s3);
            ris = (m_s2 == 1 && m_s3 == 0);
            osc = osc_pulse;
            fnd = (m_state == 0) && edg && (m_ecnt == 3);
            lst = (m_state != 0) && osc && !edg && (m_icnt == 63);
            ev  = (m_state == 2) ? ris : osc;
            tc  = ev && (m_dcnt == 21);
            nstate = m_state;
            if (m_state == 0 && fnd) nstate = 1;
            else if (m_state == 1) nstate = lst ? 0 : (tc ? 2 : 1);
            else if (m_state == 2 && lst) nstate = 0;
            if (m_state != 0 || fnd || (osc && m_wcnt == 63)) begin
                m_wcnt = 0; m_ecnt = 0;
            end else begin
                m_wcnt += osc; m_ecnt += edg;
            end
            if (m_state == 0 || lst || edg) m_icnt = 0;
            else m_icnt += osc;
            if (tc) m_dcnt = 0; else if (ev) m_dcnt++;
            m_tick  = tc;
            m_state = nstate;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = sync_pin;
        end
    end

    // ---------------- every-cycle comparison and monitors -------------------
    int cyc = 0;
    int last_tick = -1;
    int prev_tick = 0;
    int last_gap = 0;
    always @(negedge clk) begin
        #1;
        cyc++;
        if (rst_n) begin
            int exp_pwm;
            exp_pwm = (m_state != 0) || m_s2;
            check(sw_tick == m_tick, phase_req, "tick vs model", sw_tick, m_tick);
            check(pwm_only == exp_pwm, phase_req, "pwm_only vs model", pwm_only, exp_pwm);
            check(pfm_en == !pwm_only, "R9", "pfm_en complement", pfm_en, !pwm_only);
            if (sw_tick && prev_tick)
                check(0, "R9", "tick two cycles", 2, 1);
            if (sw_tick) begin
                if (last_tick >= 0) begin
                    last_gap = cyc - last_tick;
                    if (last_gap < 66) check(0, "R6", "short tick interval", last_gap, 66);
                end
                last_tick = cyc;
            end
            prev_tick = sw_tick;
        end else begin
            last_tick = -1;
            prev_tick = 0;
        end
    end

    // measure the interval between the next two ticks
    task automatic next_gap(output int g);
        int t0;
        do @(negedge clk); while (!sw_tick);
        t0 = 0;
        do begin @(negedge clk); t0++; end while (!sw_tick);
        g = t0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // ---------------- watchdog ----------------------------------------------
    initial begin
        repeat (150000) @(posedge clk);
        check(0, "WDOG", "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // ---------------- scenarios ---------------------------------------------
    initial begin
        int g;
        idle(3);
        #1.5;
        check(sw_tick == 0, "R1", "reset tick", sw_tick, 0);
        check(pwm_only == 0, "R1", "reset pwm_only", pwm_only, 0);
        check(pfm_en == 1, "R1", "reset pfm_en", pfm_en, 1);
        @(negedge clk); rst_n = 1'b1;

        phase_req = "R2";
        idle(10);
        next_gap(g); check(g == 66, "R2", "internal tick interval", g, 66);
        check(pfm_en == 1, "R3", "low level allows pfm", pfm_en, 1);

        phase_req = "R3";
        pin_level = 1;
        idle(3);
        check(pwm_only == 1, "R3", "high level forces pwm", pwm_only, 1);
        check(pfm_en == 0, "R3", "high level blocks pfm", pfm_en, 0);
        next_gap(g); check(g == 66, "R3", "tick period with static high", g, 66);
        idle(300);

        phase_req = "R4";
        pin_level = 0; idle(6);
        pin_level = 1; idle(6);
        pin_level = 0;
        idle(400);
        check(pfm_en == 1, "R4", "three edges do not select clock", pfm_en, 1);
        next_gap(g); check(g == 66, "R4", "still internal period", g, 66);

        phase_req = "R5";
        pin_toggle = 1;
        idle(400);
        check(pwm_only == 1, "R7", "clock forces pwm", pwm_only, 1);
        check(pfm_en == 0, "R7", "clock blocks pfm", pfm_en, 0);
        next_gap(g); check(g == 88, "R5", "external tick interval", g, 88);
        next_gap(g); check(g == 88, "R5", "external tick interval 2", g, 88);

        phase_req = "R8";
        pin_toggle = 0; pin_level = 0;
        idle(300);
        check(pfm_en == 1, "R8", "loss returns to auto mode", pfm_en, 1);
        next_gap(g); check(g == 66, "R8", "internal period after loss", g, 66);

        phase_req = "R6";
        pin_toggle = 1;
        idle(500);
        next_gap(g); check(g == 88, "R6", "external after re-arm", g, 88);
        phase_req = "R8";
        pin_toggle = 0; pin_level = 1;
        idle(300);
        check(pwm_only == 1, "R8", "loss with high level keeps pwm", pwm_only, 1);
        next_gap(g); check(g == 66, "R8", "internal period after loss high", g, 66);

        phase_req = "R1";
        pin_level = 0; pin_toggle = 1;
        idle(400);
        rst_n = 1'b0;
        idle(2);
        check(sw_tick == 0, "R1", "mid-run reset tick", sw_tick, 0);
        check(pwm_only == 0 || sync_pin, "R1", "mid-run reset flags", pwm_only, 0);
        pin_toggle = 0; pin_level = 0;
        idle(2);
        rst_n = 1'b1;
        idle(5);
        check(pfm_en == 1, "R1", "internal after reset", pfm_en, 1);
        phase_req = "R2";
        next_gap(g); check(g == 66, "R2", "period after reset", g, 66);

        idle(5);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule